// File: doc/BRIEF.md
# Level-2 Interrupt Controller

This block gathers the event sources of a network controller into one 32-bit sticky status word and reduces them to a single interrupt line for the CPU. Two sources have dedicated pins: transmit-DMA-complete and receive-DMA-complete. Every other source arrives on a general 32-bit event vector. Any cycle in which a source is high sets its status bit. The bit then stays set until software acknowledges it. A source may be a one-cycle pulse or a level.

Software never writes the mask directly. It writes ones to a mask-set register to hide sources, and ones to a mask-clear register to expose them. Zero bits in either write leave the mask alone. A separate acknowledge register clears status bits with write-one semantics. Software reads three values:
- the raw status word,
- the mask,
- the pending word, which is the status with the masked bits removed.

The interrupt output is a flop. It is high whenever the pending word is non-zero. It is updated on the same clock edge that changes the status or the mask.

The register port is a plain single-cycle bus. A write strobe carries an address and data. Read data is a combinational function of the address. Because the bus has no data stream, it carries no valid/ready handshake.

Top module: `irq_l2_ctrl`

## Requirements
- R1: After reset the status word is 0x0000_0000, the mask is 0xFFFF_FFFF (every source masked) and `irq_o` is low.
- R2: A cycle with a source high sets its status bit at the next clock edge. `tx_done_i` feeds status bit 0, `rx_done_i` feeds status bit 1, and `src_evt_i[n]` feeds bit n (ORed with the dedicated pins on bits 0 and 1).
- R3: Status bits latch while masked. A masked bit does not raise `irq_o` and reads as 0 in the pending word.
- R4: A write to byte offset 0x14 (acknowledge) clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: If a source is high in the same cycle that its bit is acknowledged, the bit stays set.
- R6: A write to offset 0x0C (mask-set) sets the mask bits whose data bit is 1 and leaves the others unchanged. Writing 0xFFFF_FFFF masks every source.
- R7: A write to offset 0x10 (mask-clear) clears the mask bits whose data bit is 1 and leaves the others unchanged.
- R8: Offset 0x00 reads the raw status. Offset 0x04 reads the pending word (status AND NOT mask). Offset 0x08 reads the mask.
- R9: `irq_o` is a register holding the OR of the pending word. It changes on the same edge as the state that made the pending word non-zero or zero. Unmasking an already-latched bit therefore raises `irq_o` on the edge of the mask-clear write.
- R10: Writes to offsets 0x00, 0x04, 0x08 and to unmapped offsets 0x18 and 0x1C change nothing. Reads of 0x0C, 0x10, 0x14, 0x18 and 0x1C return zero. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done_i | input | 1 | Transmit DMA completion event (status bit 0) |
| rx_done_i | input | 1 | Receive DMA completion event (status bit 1) |
| src_evt_i | input | 32 | General event sources, one per status bit |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request, high while any unmasked status bit is set |

## Verification
All state in this block is visible through the bus in the cycle after it changes. The raw status, mask and pending words are directly readable, and `irq_o` follows the pending word on the same edge.

A stuck or wrongly updated status bit therefore shows up on the very next read of offset 0x00. A mask bit lost during a set or clear write shows up at offset 0x08 and usually on `irq_o` within one cycle. A priority mistake between an event and an acknowledge in the same cycle is caught by reading the status right after that collision. A pipeline stage inserted before `irq_o` shows as the line rising one edge late after an unmask.

// File: rtl/irq_l2_pkg.sv
package irq_l2_pkg;

  // Word index of each register (byte offset / 4)
  localparam int unsigned IDX_RAW  = 0;
  localparam int unsigned IDX_PEND = 1;
  localparam int unsigned IDX_MASK = 2;
  localparam int unsigned IDX_MSET = 3;
  localparam int unsigned IDX_MCLR = 4;
  localparam int unsigned IDX_ACK  = 5;

  // Write-side strobes decoded from one bus access
  typedef struct packed {
    logic mset;
    logic mclr;
    logic ack;
  } wr_sel_t;

endpackage

// File: rtl/l2_reg_decode.sv
module l2_reg_decode
  import irq_l2_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] status_q,
  input  logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] mset_vec,
  output logic [DATA_W-1:0] mclr_vec,
  output logic [DATA_W-1:0] ack_vec,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_byte_lane;
  wr_sel_t          sel;

  assign idx              = bus_addr[ADDR_W-1:2];
  assign unused_byte_lane = bus_addr[1:0];

  always_comb begin
    sel      = '0;
    sel.mset = bus_wr && (idx == IDX_W'(IDX_MSET));
    sel.mclr = bus_wr && (idx == IDX_W'(IDX_MCLR));
    sel.ack  = bus_wr && (idx == IDX_W'(IDX_ACK));
  end

  assign mset_vec = sel.mset ? bus_wdata : '0;
  assign mclr_vec = sel.mclr ? bus_wdata : '0;
  assign ack_vec  = sel.ack  ? bus_wdata : '0;

  always_comb begin
    rdata = '0;
    if (idx == IDX_W'(IDX_RAW))       rdata = status_q;
    else if (idx == IDX_W'(IDX_PEND)) rdata = status_q & ~mask_q;
    else if (idx == IDX_W'(IDX_MASK)) rdata = mask_q;
  end

endmodule

// File: rtl/l2_status_bank.sv
module l2_status_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_vec,
  input  logic [WIDTH-1:0] ack_vec,
  output logic [WIDTH-1:0] status_q,
  output logic [WIDTH-1:0] status_d
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    // Event has priority over acknowledge in the same cycle
    assign status_d[b] = evt_vec[b] | (status_q[b] & ~ack_vec[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[b] <= 1'b0;
      else        status_q[b] <= status_d[b];
    end
  end

endmodule

// File: rtl/l2_mask_bank.sv
module l2_mask_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] mask_d
);

  assign mask_d = (mask_q | set_vec) & ~clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

endmodule

// File: rtl/irq_l2_ctrl.sv
module irq_l2_ctrl #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TX_BIT = 0,
  parameter int unsigned RX_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] src_evt_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] evt_vec;
  logic [DATA_W-1:0] mset_vec, mclr_vec, ack_vec;
  logic [DATA_W-1:0] status_q, status_d;
  logic [DATA_W-1:0] mask_q, mask_d;
  logic              irq_q;

  always_comb begin
    evt_vec         = src_evt_i;
    evt_vec[TX_BIT] = evt_vec[TX_BIT] | tx_done_i;
    evt_vec[RX_BIT] = evt_vec[RX_BIT] | rx_done_i;
  end

  l2_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .bus_wr   (bus_wr_i),
    .bus_addr (bus_addr_i),
    .bus_wdata(bus_wdata_i),
    .status_q (status_q),
    .mask_q   (mask_q),
    .mset_vec (mset_vec),
    .mclr_vec (mclr_vec),
    .ack_vec  (ack_vec),
    .rdata    (bus_rdata_o)
  );

  l2_status_bank #(.WIDTH(DATA_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_vec (evt_vec),
    .ack_vec (ack_vec),
    .status_q(status_q),
    .status_d(status_d)
  );

  l2_mask_bank #(.WIDTH(DATA_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(mset_vec),
    .clr_vec(mclr_vec),
    .mask_q (mask_q),
    .mask_d (mask_d)
  );

  // Registered from next-state so irq moves on the same edge as the banks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_d & ~mask_d);
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_l2_ctrl_chk.sv
module irq_l2_ctrl_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TX_BIT = 0,
  parameter int unsigned RX_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_done_i,
  input logic              rx_done_i,
  input logic [DATA_W-1:0] src_evt_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q
);

  logic [DATA_W-1:0] all_evt;
  logic              w_mset, w_mclr, w_ack;

  always_comb begin
    all_evt         = src_evt_i;
    all_evt[TX_BIT] = all_evt[TX_BIT] | tx_done_i;
    all_evt[RX_BIT] = all_evt[RX_BIT] | rx_done_i;
  end

  assign w_mset = bus_wr_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(3));
  assign w_mclr = bus_wr_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(4));
  assign w_ack  = bus_wr_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(5));

  // R2, R5: every source seen in a cycle is in status afterwards
  p_event_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(all_evt)) == $past(all_evt)));

  // R4: acknowledged bits without a simultaneous event are cleared
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_ack |=> ((status_q & $past(bus_wdata_i & ~all_evt)) == '0));

  // R4: with no acknowledge, status bits never drop
  p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !w_ack |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R6: mask-set raises the written bits and keeps the rest
  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    w_mset |=> (mask_q == ($past(mask_q) | $past(bus_wdata_i))));

  // R7: mask-clear drops the written bits and keeps the rest
  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w_mclr |=> (mask_q == ($past(mask_q) & ~$past(bus_wdata_i))));

  // R10: mask only moves on its own two write offsets
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_mset || w_mclr) |=> $stable(mask_q));

  // R9: the interrupt flop tracks the pending word of the banks
  p_irq_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(status_q & ~mask_q)));

endmodule

bind irq_l2_ctrl irq_l2_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TX_BIT(TX_BIT), .RX_BIT(RX_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_done_i  (tx_done_i),
  .rx_done_i  (rx_done_i),
  .src_evt_i  (src_evt_i),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .status_q   (status_q),
  .mask_q     (mask_q)
);

// File: tb/irq_l2_ctrl_test.sv
`timescale 1ns/1ps
module irq_l2_ctrl_test;

  localparam logic [4:0] A_RAW  = 5'h00;
  localparam logic [4:0] A_PEND = 5'h04;
  localparam logic [4:0] A_MASK = 5'h08;
  localparam logic [4:0] A_MSET = 5'h0C;
  localparam logic [4:0] A_MCLR = 5'h10;
  localparam logic [4:0] A_ACK  = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_done_i = 1'b0;
  logic        rx_done_i = 1'b0;
  logic [31:0] src_evt_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  irq_l2_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tx_done_i(tx_done_i), .rx_done_i(rx_done_i),
    .src_evt_i(src_evt_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic pulse(input logic [31:0] v, input logic tx, input logic rx);
    @(negedge clk);
    src_evt_i = v; tx_done_i = tx; rx_done_i = rx;
    @(negedge clk);
    src_evt_i = '0; tx_done_i = 1'b0; rx_done_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_RAW, d);  check("R1 status", d, 32'h0);
    rd(A_MASK, d); check("R1 mask", d, 32'hFFFF_FFFF);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_sources_masked();
    logic [31:0] d;
    pulse('0, 1'b1, 1'b0);
    rd(A_RAW, d); check("R2 tx_done -> bit0", d, 32'h1);
    pulse('0, 1'b0, 1'b1);
    rd(A_RAW, d); check("R2 rx_done -> bit1", d, 32'h3);
    pulse(32'h0000_0100, 1'b0, 1'b0);
    rd(A_RAW, d); check("R2 src bit8", d, 32'h103);
    rd(A_PEND, d); check("R3 pending while masked", d, 32'h0);
    check("R3 irq while masked", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_unmask_timing();
    logic [31:0] d;
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = A_MCLR; bus_wdata_i = 32'h0000_0001;
    #1 check("R9 irq before edge", {31'b0, irq_o}, 32'h0);
    @(posedge clk); #1;
    check("R9 irq on unmask edge", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    bus_wr_i = 1'b0; bus_wdata_i = '0;
    rd(A_MASK, d); check("R7 clear bit0 only", d, 32'hFFFF_FFFE);
    rd(A_PEND, d); check("R8 pending", d, 32'h1);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(A_ACK, 32'h0000_0002);
    rd(A_RAW, d); check("R4 ack bit1 keeps others", d, 32'h101);
    check("R4 irq still high", {31'b0, irq_o}, 32'h1);
    wr(A_ACK, 32'h0000_0101);
    rd(A_RAW, d); check("R4 ack remaining", d, 32'h0);
    check("R9 irq drops", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk);
    src_evt_i = 32'h0000_0020;
    bus_wr_i = 1'b1; bus_addr_i = A_ACK; bus_wdata_i = 32'h0000_0020;
    @(negedge clk);
    src_evt_i = '0; bus_wr_i = 1'b0; bus_wdata_i = '0;
    rd(A_RAW, d); check("R5 event beats ack", d, 32'h20);
    wr(A_ACK, 32'h0000_0020);
    rd(A_RAW, d); check("R4 later ack clears", d, 32'h0);
  endtask

  task automatic t_mask_set();
    logic [31:0] d;
    wr(A_MCLR, 32'hFFFF_FFFF);
    rd(A_MASK, d); check("R7 clear all", d, 32'h0);
    wr(A_MSET, 32'h0000_F00F);
    rd(A_MASK, d); check("R6 set subset", d, 32'h0000_F00F);
    wr(A_MSET, 32'h0F00_0000);
    rd(A_MASK, d); check("R6 set keeps others", d, 32'h0F00_F00F);
    pulse(32'h0000_0400, 1'b0, 1'b0);
    check("R9 unmasked event", {31'b0, irq_o}, 32'h1);
    rd(A_PEND, d); check("R8 pending bit10", d, 32'h400);
    wr(A_MSET, 32'hFFFF_FFFF);
    rd(A_MASK, d); check("R6 all ones", d, 32'hFFFF_FFFF);
    check("R6 irq masked", {31'b0, irq_o}, 32'h0);
    rd(A_RAW, d); check("R3 still latched", d, 32'h400);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(A_RAW,  32'hFFFF_FFFF);
    wr(A_PEND, 32'hFFFF_FFFF);
    wr(A_MASK, 32'h0);
    wr(5'h18,  32'hFFFF_FFFF);
    wr(5'h1C,  32'hFFFF_FFFF);
    rd(A_RAW, d);  check("R10 status untouched", d, 32'h400);
    rd(A_MASK, d); check("R10 mask untouched", d, 32'hFFFF_FFFF);
    rd(A_MSET, d); check("R10 mset reads 0", d, 32'h0);
    rd(A_MCLR, d); check("R10 mclr reads 0", d, 32'h0);
    rd(A_ACK, d);  check("R10 ack reads 0", d, 32'h0);
    rd(5'h18, d);  check("R10 unmapped reads 0", d, 32'h0);
    rd(5'h0B, d);  check("R10 low bits ignored", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sources_masked();
    t_unmask_timing();
    t_ack();
    t_collision();
    t_mask_set();
    t_readonly();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule